// File: doc/BRIEF.md
# Speculative Load Address Tracker

This block remembers loads that a scheduler has hoisted above stores that might alias them. Each hoisted load writes one entry, found later by its destination register number, holding the byte address, the access size and a small load-type code. Every store is snooped against all live entries, and any entry whose byte range the store touches is dropped. A check request names a register and a type, and the block answers within the same cycle whether the hoisted value can still be trusted. A miss means the consumer has to re-execute the load.

The table is fully associative. A load to a register that already has an entry rewrites that entry in place. Otherwise the load takes the lowest-numbered free slot. When no slot is free, a rotating victim pointer picks the slot to overwrite. A flush empties the table, for example on a context switch. A check may also ask for its entry to be removed once it hits.

Top module: `spec_load_table`

## Requirements
- R1: After a synchronous reset (rst high at a rising edge) the table holds no entries, and every check reports a miss.
- R2: From the cycle after an accepted load (ld_valid high at a rising edge), a check with the same register number and the same type reports a hit.
- R3: A check reports a miss when no live entry has its register number, or when the matching entry holds a different type code.
- R4: Size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. An entry at start E with size e and a store at start S with size s overlap when S < E+e and E < S+s. Both sums are taken without wraparound. A store that overlaps a live entry removes that entry at the next rising edge.
- R5: A store whose byte range only abuts an entry's range, or lies elsewhere, leaves that entry live.
- R6: A load to a register that already has a live entry overwrites that entry in place. The previous address and type no longer take effect, and no other slot is used.
- R7: A flush removes every entry at the next rising edge and returns the victim pointer to slot 0. A load in the same cycle as a flush is dropped.
- R8: A load to a new register takes the lowest free slot. When all slots are full, it overwrites the slot chosen by a victim pointer. That pointer starts at slot 0 and moves to the next slot after each eviction, so on a full table evictions follow fill order.
- R9: A check that arrives in the same cycle as a store overlapping the checked entry reports a miss. A non-overlapping store in that cycle does not change the answer.
- R10: A check with ck_clear high that hits removes the entry at the next rising edge. A clearing check that misses has no effect.
- R11: A store in the same cycle as a load does not affect the entry that load writes. It still removes any other overlapping entry.
- R12: ck_hit is combinational: it answers in the same cycle as the request and is low whenever ck_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Hoisted load is recorded this cycle |
| ld_reg | input | 7 | Destination register number of the load |
| ld_addr | input | 64 | Byte address of the load |
| ld_size | input | 2 | Load size code (1/2/4/8 bytes) |
| ld_type | input | 2 | Load type code |
| st_valid | input | 1 | Store snoop is valid this cycle |
| st_addr | input | 64 | Byte address of the store |
| st_size | input | 2 | Store size code |
| flush | input | 1 | Empty the whole table |
| ck_valid | input | 1 | Check request is valid |
| ck_reg | input | 7 | Register number being checked |
| ck_type | input | 2 | Type code expected by the check |
| ck_clear | input | 1 | Remove the entry if the check hits |
| ck_hit | output | 1 | Combinational hit answer for the check |

## Verification
Because the only observable output is the hit answer, corrupted state shows up as a wrong hit or a wrong miss on the first check of the affected register. A stale valid bit turns an expected miss into a false hit. A range-compare error that is off by one byte flips the answer for stores that abut an entry. A victim pointer that is off by one slot makes the wrong register miss on the first eviction after the table fills. The directed scenarios therefore probe each register right after the edge that should change it, and they also probe the neighbouring registers that should not change.

// File: rtl/spec_load_pkg.sv
package spec_load_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } size_code_t;

  localparam int unsigned DEF_ENTRIES = 8;
  localparam int unsigned DEF_REG_W   = 7;
  localparam int unsigned DEF_ADDR_W  = 64;
  localparam int unsigned DEF_TYPE_W  = 2;

endpackage

// File: rtl/spec_load_entry.sv
module spec_load_entry #(
  parameter int unsigned REG_W  = spec_load_pkg::DEF_REG_W,
  parameter int unsigned ADDR_W = spec_load_pkg::DEF_ADDR_W,
  parameter int unsigned TYPE_W = spec_load_pkg::DEF_TYPE_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     flush,
  input  logic                     wr_en,
  input  logic [REG_W-1:0]         wr_reg,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  spec_load_pkg::size_code_t wr_size,
  input  logic [TYPE_W-1:0]        wr_type,
  input  logic                     st_valid,
  input  logic [ADDR_W-1:0]        st_addr,
  input  spec_load_pkg::size_code_t st_size,
  input  logic                     kill,
  output logic                     valid,
  output logic [REG_W-1:0]         tag_reg,
  output logic [TYPE_W-1:0]        tag_type,
  output logic                     snoop_hit
);
  // One extra bit keeps range ends from wrapping past the top of memory.
  localparam int unsigned EXT_W = ADDR_W + 1;

  logic [ADDR_W-1:0]         addr_q;
  spec_load_pkg::size_code_t size_q;

  logic [EXT_W-1:0] ent_lo, ent_hi, st_lo, st_hi;
  logic [EXT_W-1:0] ent_len, st_len;

  always_comb begin
    ent_len   = {{(EXT_W-1){1'b0}}, 1'b1} << size_q;
    st_len    = {{(EXT_W-1){1'b0}}, 1'b1} << st_size;
    ent_lo    = {1'b0, addr_q};
    st_lo     = {1'b0, st_addr};
    ent_hi    = ent_lo + ent_len;
    st_hi     = st_lo + st_len;
    snoop_hit = valid && st_valid && (st_lo < ent_hi) && (ent_lo < st_hi);
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      valid    <= 1'b0;
      tag_reg  <= '0;
      tag_type <= '0;
      addr_q   <= '0;
      size_q   <= spec_load_pkg::SZ_BYTE;
    end else if (wr_en) begin
      valid    <= 1'b1;
      tag_reg  <= wr_reg;
      tag_type <= wr_type;
      addr_q   <= wr_addr;
      size_q   <= wr_size;
    end else if (snoop_hit || kill) begin
      valid    <= 1'b0;
    end
  end

endmodule

// File: rtl/spec_load_alloc.sv
module spec_load_alloc #(
  parameter int unsigned ENTRIES = spec_load_pkg::DEF_ENTRIES,
  parameter int unsigned REG_W   = spec_load_pkg::DEF_REG_W
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            flush,
  input  logic                            ld_valid,
  input  logic [REG_W-1:0]                ld_reg,
  input  logic [ENTRIES-1:0]              ent_valid,
  input  logic [ENTRIES-1:0][REG_W-1:0]   ent_reg,
  output logic [ENTRIES-1:0]              wr_vec
);
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] victim_q;
  logic [IDX_W-1:0] same_idx, free_idx, sel_idx;
  logic             same_any, free_any;

  always_comb begin
    same_any = 1'b0;
    free_any = 1'b0;
    same_idx = '0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (ent_valid[i] && ent_reg[i] == ld_reg) begin
        same_any = 1'b1;
        same_idx = IDX_W'(i);
      end
      if (!ent_valid[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
    if (same_any)      sel_idx = same_idx;
    else if (free_any) sel_idx = free_idx;
    else               sel_idx = victim_q;
    wr_vec = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (ld_valid && sel_idx == IDX_W'(i)) wr_vec[i] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || flush)
      victim_q <= '0;
    else if (ld_valid && !same_any && !free_any)
      victim_q <= (victim_q == LAST) ? '0 : victim_q + 1'b1;
  end

endmodule

// File: rtl/spec_load_lookup.sv
module spec_load_lookup #(
  parameter int unsigned ENTRIES = spec_load_pkg::DEF_ENTRIES,
  parameter int unsigned REG_W   = spec_load_pkg::DEF_REG_W,
  parameter int unsigned TYPE_W  = spec_load_pkg::DEF_TYPE_W
) (
  input  logic                            ck_valid,
  input  logic [REG_W-1:0]                ck_reg,
  input  logic [TYPE_W-1:0]               ck_type,
  input  logic [ENTRIES-1:0]              ent_valid,
  input  logic [ENTRIES-1:0][REG_W-1:0]   ent_reg,
  input  logic [ENTRIES-1:0][TYPE_W-1:0]  ent_type,
  input  logic [ENTRIES-1:0]              snoop_vec,
  output logic [ENTRIES-1:0]              hit_vec,
  output logic                            hit
);
  // A same-cycle overlapping store wins over the check.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = ck_valid && ent_valid[g] && !snoop_vec[g] &&
                        (ent_reg[g] == ck_reg) && (ent_type[g] == ck_type);
  end

  assign hit = |hit_vec;

endmodule

// File: rtl/spec_load_table.sv
module spec_load_table #(
  parameter int unsigned ENTRIES = spec_load_pkg::DEF_ENTRIES,
  parameter int unsigned REG_W   = spec_load_pkg::DEF_REG_W,
  parameter int unsigned ADDR_W  = spec_load_pkg::DEF_ADDR_W,
  parameter int unsigned TYPE_W  = spec_load_pkg::DEF_TYPE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  input  logic [REG_W-1:0]  ld_reg,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [1:0]        ld_size,
  input  logic [TYPE_W-1:0] ld_type,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [1:0]        st_size,
  input  logic              flush,
  input  logic              ck_valid,
  input  logic [REG_W-1:0]  ck_reg,
  input  logic [TYPE_W-1:0] ck_type,
  input  logic              ck_clear,
  output logic              ck_hit
);
  logic [ENTRIES-1:0]             ent_valid;
  logic [ENTRIES-1:0][REG_W-1:0]  ent_reg;
  logic [ENTRIES-1:0][TYPE_W-1:0] ent_type;
  logic [ENTRIES-1:0]             snoop_vec;
  logic [ENTRIES-1:0]             wr_vec;
  logic [ENTRIES-1:0]             hit_vec;
  logic [ENTRIES-1:0]             kill_vec;

  spec_load_pkg::size_code_t ld_code, st_code;
  assign ld_code = spec_load_pkg::size_code_t'(ld_size);
  assign st_code = spec_load_pkg::size_code_t'(st_size);

  spec_load_alloc #(.ENTRIES(ENTRIES), .REG_W(REG_W)) u_alloc (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .ld_valid  (ld_valid),
    .ld_reg    (ld_reg),
    .ent_valid (ent_valid),
    .ent_reg   (ent_reg),
    .wr_vec    (wr_vec)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    spec_load_entry #(.REG_W(REG_W), .ADDR_W(ADDR_W), .TYPE_W(TYPE_W)) u_ent (
      .clk       (clk),
      .rst       (rst),
      .flush     (flush),
      .wr_en     (wr_vec[g]),
      .wr_reg    (ld_reg),
      .wr_addr   (ld_addr),
      .wr_size   (ld_code),
      .wr_type   (ld_type),
      .st_valid  (st_valid),
      .st_addr   (st_addr),
      .st_size   (st_code),
      .kill      (kill_vec[g]),
      .valid     (ent_valid[g]),
      .tag_reg   (ent_reg[g]),
      .tag_type  (ent_type[g]),
      .snoop_hit (snoop_vec[g])
    );
  end

  spec_load_lookup #(.ENTRIES(ENTRIES), .REG_W(REG_W), .TYPE_W(TYPE_W)) u_lookup (
    .ck_valid  (ck_valid),
    .ck_reg    (ck_reg),
    .ck_type   (ck_type),
    .ent_valid (ent_valid),
    .ent_reg   (ent_reg),
    .ent_type  (ent_type),
    .snoop_vec (snoop_vec),
    .hit_vec   (hit_vec),
    .hit       (ck_hit)
  );

  assign kill_vec = hit_vec & {ENTRIES{ck_clear}};

endmodule

// File: rtl/spec_load_table_chk.sv
module spec_load_table_chk #(
  parameter int unsigned ENTRIES = spec_load_pkg::DEF_ENTRIES
) (
  input logic               clk,
  input logic               rst,
  input logic               flush,
  input logic               ld_valid,
  input logic               st_valid,
  input logic               ck_valid,
  input logic               ck_clear,
  input logic               ck_hit,
  input logic [ENTRIES-1:0] ent_valid
);
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush |=> (ent_valid == '0)); // R7

  AST_LOAD_FILLS: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && !flush) |=> (ent_valid != '0)); // R2

  AST_HIT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    ck_hit |-> ck_valid); // R12

  AST_CLEAR_DROPS_ONE: assert property (@(posedge clk) disable iff (rst)
    (ck_valid && ck_clear && ck_hit && !ld_valid && !st_valid && !flush) |=>
    ($countones(ent_valid) + 1 == $countones($past(ent_valid)))); // R10

  AST_LOAD_NO_SHRINK: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && !flush && !st_valid && !(ck_valid && ck_clear)) |=>
    ($countones(ent_valid) >= $countones($past(ent_valid)))); // R8

  AST_STORE_NO_GROW: assert property (@(posedge clk) disable iff (rst)
    (st_valid && !ld_valid) |=>
    ($countones(ent_valid) <= $countones($past(ent_valid)))); // R4

endmodule

bind spec_load_table spec_load_table_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .flush     (flush),
  .ld_valid  (ld_valid),
  .st_valid  (st_valid),
  .ck_valid  (ck_valid),
  .ck_clear  (ck_clear),
  .ck_hit    (ck_hit),
  .ent_valid (ent_valid)
);

// File: tb/test_spec_load_table.sv
`timescale 1ns/1ps
module test_spec_load_table;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_valid = 1'b0;
  logic [6:0]  ld_reg = '0;
  logic [63:0] ld_addr = '0;
  logic [1:0]  ld_size = '0;
  logic [1:0]  ld_type = '0;
  logic        st_valid = 1'b0;
  logic [63:0] st_addr = '0;
  logic [1:0]  st_size = '0;
  logic        flush = 1'b0;
  logic        ck_valid = 1'b0;
  logic [6:0]  ck_reg = '0;
  logic [1:0]  ck_type = '0;
  logic        ck_clear = 1'b0;
  logic        ck_hit;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spec_load_table i_spec_load_table (
    .clk(clk), .rst(rst),
    .ld_valid(ld_valid), .ld_reg(ld_reg), .ld_addr(ld_addr), .ld_size(ld_size), .ld_type(ld_type),
    .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size),
    .flush(flush),
    .ck_valid(ck_valid), .ck_reg(ck_reg), .ck_type(ck_type), .ck_clear(ck_clear),
    .ck_hit(ck_hit)
  );

  task automatic chk(string req, string what, logic got, logic exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_load(logic [6:0] r, logic [63:0] a, logic [1:0] s, logic [1:0] t);
    ld_valid = 1'b1; ld_reg = r; ld_addr = a; ld_size = s; ld_type = t;
    tick();
    ld_valid = 1'b0;
  endtask

  task automatic do_store(logic [63:0] a, logic [1:0] s);
    st_valid = 1'b1; st_addr = a; st_size = s;
    tick();
    st_valid = 1'b0;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    tick();
    flush = 1'b0;
  endtask

  // Combinational probe, no clock edge consumed.
  task automatic probe(string req, logic [6:0] r, logic [1:0] t, logic exp);
    ck_valid = 1'b1; ck_reg = r; ck_type = t; ck_clear = 1'b0;
    #1;
    chk(req, $sformatf("check reg %0d type %0d", r, t), ck_hit, exp);
    ck_valid = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    probe("R1", 7'd0, 2'd0, 1'b0);
    probe("R1", 7'd5, 2'd1, 1'b0);
    probe("R1", 7'd127, 2'd3, 1'b0);
  endtask

  task automatic t_basic();
    do_flush();
    ld_valid = 1'b1; ld_reg = 7'd10; ld_addr = 64'h1000; ld_size = 2'd3; ld_type = 2'd1;
    ck_valid = 1'b1; ck_reg = 7'd10; ck_type = 2'd1;
    #1;
    chk("R2", "no hit before load edge", ck_hit, 1'b0);
    ck_valid = 1'b0;
    tick();
    ld_valid = 1'b0;
    probe("R2", 7'd10, 2'd1, 1'b1);
    probe("R12", 7'd10, 2'd1, 1'b1);
    #1;
    chk("R12", "no hit without request", ck_hit, 1'b0);
    probe("R3", 7'd10, 2'd2, 1'b0);
    probe("R3", 7'd11, 2'd1, 1'b0);
  endtask

  task automatic t_store();
    do_flush();
    do_load(7'd1, 64'h100, 2'd2, 2'd0);
    do_load(7'd2, 64'h200, 2'd3, 2'd0);
    do_load(7'd3, 64'h300, 2'd0, 2'd0);
    do_load(7'd4, 64'h400, 2'd1, 2'd0);
    do_store(64'h104, 2'd2);
    probe("R5", 7'd1, 2'd0, 1'b1);
    do_store(64'h0FC, 2'd2);
    probe("R5", 7'd1, 2'd0, 1'b1);
    do_store(64'h103, 2'd0);
    probe("R4", 7'd1, 2'd0, 1'b0);
    do_store(64'h1FE, 2'd2);
    probe("R4", 7'd2, 2'd0, 1'b0);
    do_store(64'h2F8, 2'd3);
    probe("R5", 7'd3, 2'd0, 1'b1);
    probe("R5", 7'd4, 2'd0, 1'b1);
    do_store(64'h401, 2'd0);
    probe("R4", 7'd4, 2'd0, 1'b0);
    probe("R5", 7'd3, 2'd0, 1'b1);
  endtask

  task automatic t_wrap();
    do_flush();
    do_load(7'd20, 64'hFFFF_FFFF_FFFF_FFF8, 2'd3, 2'd2);
    do_store(64'h0, 2'd3);
    probe("R4", 7'd20, 2'd2, 1'b1);
    do_store(64'hFFFF_FFFF_FFFF_FFFF, 2'd0);
    probe("R4", 7'd20, 2'd2, 1'b0);
  endtask

  task automatic t_replace();
    do_flush();
    do_load(7'd5, 64'h10, 2'd2, 2'd0);
    do_load(7'd5, 64'h80, 2'd2, 2'd3);
    probe("R6", 7'd5, 2'd0, 1'b0);
    probe("R6", 7'd5, 2'd3, 1'b1);
    do_store(64'h10, 2'd2);
    probe("R6", 7'd5, 2'd3, 1'b1);
    for (int i = 0; i < 7; i++) do_load(7'(40 + i), 64'(32'h1000 + i * 16), 2'd2, 2'd0);
    probe("R6", 7'd5, 2'd3, 1'b1);
    for (int i = 0; i < 7; i++) probe("R6", 7'(40 + i), 2'd0, 1'b1);
  endtask

  task automatic t_flush();
    do_flush();
    probe("R7", 7'd5, 2'd3, 1'b0);
    probe("R7", 7'd40, 2'd0, 1'b0);
    flush = 1'b1;
    ld_valid = 1'b1; ld_reg = 7'd9; ld_addr = 64'h900; ld_size = 2'd0; ld_type = 2'd0;
    tick();
    flush = 1'b0; ld_valid = 1'b0;
    probe("R7", 7'd9, 2'd0, 1'b0);
  endtask

  task automatic t_evict();
    do_flush();
    for (int i = 0; i < 8; i++) do_load(7'(50 + i), 64'(32'h2000 + i * 16), 2'd3, 2'd1);
    do_load(7'd60, 64'h3000, 2'd3, 2'd1);
    probe("R8", 7'd50, 2'd1, 1'b0);
    for (int i = 1; i < 8; i++) probe("R8", 7'(50 + i), 2'd1, 1'b1);
    probe("R8", 7'd60, 2'd1, 1'b1);
    do_load(7'd61, 64'h3100, 2'd3, 2'd1);
    probe("R8", 7'd51, 2'd1, 1'b0);
    probe("R8", 7'd52, 2'd1, 1'b1);
    do_load(7'd60, 64'h3200, 2'd3, 2'd1);
    probe("R8", 7'd52, 2'd1, 1'b1);
    probe("R8", 7'd61, 2'd1, 1'b1);
  endtask

  task automatic t_same_cycle();
    do_flush();
    do_load(7'd30, 64'h500, 2'd2, 2'd0);
    st_valid = 1'b1; st_addr = 64'h600; st_size = 2'd0;
    probe("R9", 7'd30, 2'd0, 1'b1);
    st_addr = 64'h502;
    probe("R9", 7'd30, 2'd0, 1'b0);
    tick();
    st_valid = 1'b0;
    probe("R9", 7'd30, 2'd0, 1'b0);
  endtask

  task automatic t_clear();
    do_flush();
    do_load(7'd31, 64'h800, 2'd2, 2'd2);
    do_load(7'd32, 64'h810, 2'd2, 2'd2);
    ck_valid = 1'b1; ck_reg = 7'd31; ck_type = 2'd2; ck_clear = 1'b1;
    #1;
    chk("R10", "clearing check hits", ck_hit, 1'b1);
    tick();
    ck_valid = 1'b0; ck_clear = 1'b0;
    probe("R10", 7'd31, 2'd2, 1'b0);
    ck_valid = 1'b1; ck_reg = 7'd32; ck_type = 2'd1; ck_clear = 1'b1;
    tick();
    ck_valid = 1'b0; ck_clear = 1'b0;
    probe("R10", 7'd32, 2'd2, 1'b1);
  endtask

  task automatic t_load_store();
    do_flush();
    do_load(7'd34, 64'h700, 2'd2, 2'd0);
    ld_valid = 1'b1; ld_reg = 7'd35; ld_addr = 64'h700; ld_size = 2'd2; ld_type = 2'd0;
    st_valid = 1'b1; st_addr = 64'h700; st_size = 2'd2;
    tick();
    ld_valid = 1'b0; st_valid = 1'b0;
    probe("R11", 7'd35, 2'd0, 1'b1);
    probe("R11", 7'd34, 2'd0, 1'b0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    t_reset();
    t_basic();
    t_store();
    t_wrap();
    t_replace();
    t_flush();
    t_evict();
    t_same_cycle();
    t_clear();
    t_load_store();
    done = 1'b1;
    summary();
    $finish;
  end

endmodule